// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block is the serial transmit engine of a register-compatible UART. Software places a byte in a one-entry holding register. When the bit shifter is idle the byte moves into it. The shifter then sends it on a single serial line, least significant bit first, with a low start bit in front. The line rests high between frames.

The frame shape comes from a seven-bit line control word. That word sets the word length (5 to 8 bits), an optional parity bit (even, odd, or a fixed mark or space value), one or two stop bits, and a forced break. An external baud-tick enable paces the bit timing: each bit lasts 16 ticks.

Two status outputs feed the surrounding interrupt and status logic. One says the holding register can take a new byte. The other says the whole transmit path has drained.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset `stx` is 1 and both `hold_empty` and `tx_empty` are 1. Whenever no frame is in progress and break is off, `stx` is 1.
- R2: A frame begins with one start bit at 0. The data bits follow, least significant first. The word length is `line_ctrl[1:0]`: code 0, 1, 2, 3 gives 5, 6, 7, 8 data bits; the upper data bits are not sent. The format is captured when the byte enters the shifter.
- R3: When `line_ctrl[3]` is 1 and `line_ctrl[5]` is 0, one parity bit follows the data. With `line_ctrl[4]`=1 the count of ones over the data bits and the parity bit is even; with `line_ctrl[4]`=0 it is odd.
- R4: When `line_ctrl[3]` and `line_ctrl[5]` are both 1, the parity bit is a constant: 1 if `line_ctrl[4]` is 0, and 0 if `line_ctrl[4]` is 1.
- R5: The stop bits are 1. With `line_ctrl[2]`=0 there is one stop bit. With `line_ctrl[2]`=1 there are two, except with a 5-bit word, where the second stop bit lasts half a bit time.
- R6: Every bit lasts exactly 16 clock edges on which `baud_tick` is 1. Edges without a tick do not advance the frame. The frame starts on the edge that loads the shifter, and a tick on that edge is not counted.
- R7: While `line_ctrl[6]` is 1, `stx` is 0 in the same cycle, whether a frame is in progress or not. Frame timing continues underneath.
- R8: A write with `hold_empty`=1 clears `hold_empty` on the next edge. On the first edge at which the holding register is full and the shifter is idle, the byte moves to the shifter, `hold_empty` returns to 1 and the start bit appears. The next frame therefore begins one clock after the previous stop bit ends.
- R9: `tx_empty` is 1 only when the holding register is empty and no frame is in progress. It falls on the edge after an accepted write and rises on the edge that ends the last stop bit.
- R10: A write while `hold_empty` is 0 is ignored. The held byte is kept and the ignored byte never appears on `stx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling tick enable, 16 per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| line_ctrl | input | 7 | Frame format: [1:0] word length, [2] stop count, [3] parity on, [4] even select, [5] stick parity, [6] break |
| stx | output | 1 | Serial transmit line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
On every cycle the assertions check the following:
- break forces the line low;
- the idle line stays high;
- a held byte stays unchanged until it is transferred;
- a transfer empties the holding register and starts the shifter with a low start bit;
- an accepted write clears the transmitter-empty flag.

Other properties need whole frames, and only the bench's scenarios show them. These are the bit order, the parity value in each mode, the stop length (including the one-and-a-half case), the exact tick count of a frame under gapped ticks, back-to-back frames, and a write to a full holding register never reaching the line. The bench samples each bit at its midpoint, counted in ticks, and compares against values it computes from the line control word.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // Line control word layout; field positions are decoded by the frame builder.
    typedef struct packed {
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_ctrl_t;

    localparam int MIN_WORD = 5;

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        // a write is only accepted into an empty register
        if (wr_en && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;

endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build #(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int BITS_W  = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [1:0]         wlen,
    input  logic               par_en,
    input  logic               even,
    input  logic               stick,
    input  logic               two_stop,
    output logic [FRAME_W-1:0] frame,
    output logic [BITS_W-1:0]  nbits,
    output logic               half_last
);

    import uart_tx_pkg::*;

    int   nword;
    logic ones_odd;
    logic par_bit;

    always_comb begin
        nword    = MIN_WORD + int'(wlen);
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nword) begin
                ones_odd = ones_odd ^ data[i];
            end
        end
        if (stick) begin
            par_bit = ~even;
        end else begin
            par_bit = even ? ones_odd : ~ones_odd;
        end

        // vector is shifted out from bit 0; unused positions stay at stop level
        frame    = '1;
        frame[0] = 1'b0;
        for (int j = 1; j < FRAME_W; j++) begin
            if (j <= nword) begin
                frame[j] = data[j-1];
            end else if (par_en && (j == nword + 1)) begin
                frame[j] = par_bit;
            end
        end

        nbits     = BITS_W'(2 + nword + int'(par_en) + int'(two_stop));
        half_last = two_stop && (wlen == 2'd0);
    end

endmodule

// File: rtl/tx_bit_shifter.sv
module tx_bit_shifter #(
    parameter int FRAME_W       = 12,
    parameter int BITS_W        = $clog2(FRAME_W + 1),
    parameter int TICKS_PER_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [BITS_W-1:0]  nbits,
    input  logic               half_last,
    output logic               busy,
    output logic               ser_bit
);

    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(TICKS_PER_BIT / 2 - 1);

    typedef struct packed {
        logic               busy;
        logic               half;
        logic [FRAME_W-1:0] sh;
        logic [BITS_W-1:0]  left;
        logic [CNT_W-1:0]   tick;
    } shift_t;

    shift_t           st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = (st_q.half && (st_q.left == BITS_W'(1))) ? HALF_LIM : FULL_LIM;
        if (!st_q.busy) begin
            if (load) begin
                st_d.busy = 1'b1;
                st_d.half = half_last;
                st_d.sh   = frame;
                st_d.left = nbits;
                st_d.tick = '0;
            end
        end else if (baud_tick) begin
            if (st_q.tick == limit) begin
                st_d.tick = '0;
                st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.left = st_q.left - BITS_W'(1);
                if (st_q.left == BITS_W'(1)) begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.tick = st_q.tick + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sh   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign ser_bit = st_q.sh[0];

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [6:0]        line_ctrl,
    output logic              stx,
    output logic              hold_empty,
    output logic              tx_empty
);

    import uart_tx_pkg::*;

    localparam int FRAME_W = DATA_W + 4;
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    line_ctrl_t         ctrl;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               take;
    logic               sh_busy;
    logic               sh_bit;
    logic [FRAME_W-1:0] frame;
    logic [BITS_W-1:0]  nbits;
    logic               half_last;

    assign ctrl = line_ctrl_t'(line_ctrl);
    assign take = hold_full && !sh_busy;

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    tx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .BITS_W(BITS_W)) u_build (
        .data      (hold_data),
        .wlen      (ctrl.wlen),
        .par_en    (ctrl.par_en),
        .even      (ctrl.even),
        .stick     (ctrl.stick),
        .two_stop  (ctrl.two_stop),
        .frame     (frame),
        .nbits     (nbits),
        .half_last (half_last)
    );

    tx_bit_shifter #(.FRAME_W(FRAME_W), .BITS_W(BITS_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .load      (take),
        .frame     (frame),
        .nbits     (nbits),
        .half_last (half_last),
        .busy      (sh_busy),
        .ser_bit   (sh_bit)
    );

    always_comb begin
        if (ctrl.brk) begin
            stx = 1'b0;
        end else if (sh_busy) begin
            stx = sh_bit;
        end else begin
            stx = 1'b1;
        end
    end

    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !sh_busy;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              brk,
    input logic              wr_en,
    input logic              stx,
    input logic              hold_empty,
    input logic              tx_empty,
    input logic              take,
    input logic              busy,
    input logic [DATA_W-1:0] hold_data
);

    // R7
    brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !stx);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |-> stx);

    // R8
    take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (hold_empty && busy));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !brk) |-> !stx);

    // R10
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !take) |=> (!hold_empty && $stable(hold_data)));

    // R9
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> !tx_empty);

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk        (line_ctrl[6]),
    .wr_en      (wr_en),
    .stx        (stx),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .take       (take),
    .busy       (sh_busy),
    .hold_data  (hold_data)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] line_ctrl = 7'h03;
    logic       stx;
    logic       hold_empty;
    logic       tx_empty;

    int  checks = 0;
    int  errors = 0;
    bit  tick_gappy = 1'b0;

    always #5 clk = ~clk;

    uart_frame_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .line_ctrl  (line_ctrl),
        .stx        (stx),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    always @(negedge clk) begin
        baud_tick <= tick_gappy ? 1'($urandom % 2) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nword(input logic [6:0] lc);
        return 5 + int'(lc[1:0]);
    endfunction

    function automatic int nbits_exp(input logic [6:0] lc);
        return 2 + nword(lc) + int'(lc[3]) + int'(lc[2]);
    endfunction

    function automatic bit half_exp(input logic [6:0] lc);
        return lc[2] && (lc[1:0] == 2'd0);
    endfunction

    function automatic int total_exp(input logic [6:0] lc);
        return 16 * (nbits_exp(lc) - 1) + (half_exp(lc) ? 8 : 16);
    endfunction

    function automatic bit bit_exp(input logic [7:0] d, input logic [6:0] lc, input int k);
        int ones;
        if (k == 0) return 1'b0;
        if (k <= nword(lc)) return d[k-1];
        if (lc[3] && k == nword(lc) + 1) begin
            if (lc[5]) return ~lc[4];
            ones = 0;
            for (int i = 0; i < nword(lc); i++) ones += int'(d[i]);
            return lc[4] ? 1'(ones % 2) : ~1'(ones % 2);
        end
        return 1'b1;
    endfunction

    function automatic string tag_of(input logic [6:0] lc, input int k);
        if (k <= nword(lc)) return "R2";
        if (lc[3] && k == nword(lc) + 1) return lc[5] ? "R4" : "R3";
        return "R5";
    endfunction

    // called at a negedge
    task automatic write_byte(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // entered at the negedge where the start bit is first visible
    task automatic rx_frame(input logic [7:0] d, input logic [6:0] lc, input bit empty_end);
        int  cnt = 0;
        int  tot = total_exp(lc);
        int  nb  = nbits_exp(lc);
        int  k;
        bit  inc;
        bit  brk = lc[6];
        while (cnt < tot) begin
            @(posedge clk);
            inc = baud_tick;
            @(negedge clk);
            if (inc) begin
                cnt++;
                k = -1;
                if ((cnt % 16 == 8) && (cnt / 16 < nb - (half_exp(lc) ? 1 : 0))) k = cnt / 16;
                if (half_exp(lc) && cnt == 16 * (nb - 1) + 4) k = nb - 1;
                if (k >= 0) begin
                    chk(stx == (brk ? 1'b0 : bit_exp(d, lc, k)),
                        brk ? "R7" : tag_of(lc, k), int'(stx), int'(brk ? 1'b0 : bit_exp(d, lc, k)));
                end
                if (cnt == tot - 1) chk(tx_empty == 1'b0, "R6", int'(tx_empty), 0);
            end
        end
        chk(tx_empty == empty_end, "R9", int'(tx_empty), int'(empty_end));
        chk(stx == !brk, "R1", int'(stx), int'(!brk));
    endtask

    // called at a negedge with the transmitter idle
    task automatic send_check(input logic [7:0] d, input logic [6:0] lc);
        line_ctrl = lc;
        write_byte(d);
        chk(hold_empty == 1'b0, "R8", int'(hold_empty), 0);
        chk(tx_empty == 1'b0, "R9", int'(tx_empty), 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R8", int'(hold_empty), 1);
        chk(stx == 1'b0, "R2", int'(stx), 0);
        rx_frame(d, lc, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit stayed_high;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(stx == 1'b1, "R1", int'(stx), 1);
        chk(hold_empty == 1'b1, "R1", int'(hold_empty), 1);
        chk(tx_empty == 1'b1, "R1", int'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(stx == 1'b1, "R1", int'(stx), 1);

        // R2 every word length, no parity, one stop
        send_check(8'hA5, 7'b000_0000);
        send_check(8'h96, 7'b000_0001);
        send_check(8'h3C, 7'b000_0010);
        send_check(8'hD2, 7'b000_0011);
        // R3 even and odd parity
        send_check(8'hB7, 7'b001_1011);
        send_check(8'hB7, 7'b000_1011);
        send_check(8'h13, 7'b001_1000);
        // R4 mark and space
        send_check(8'h00, 7'b010_1011);
        send_check(8'hFF, 7'b011_1011);
        // R5 one and a half, and two stop bits
        send_check(8'h15, 7'b000_0100);
        send_check(8'h6E, 7'b000_0110);
        // R6 gapped ticks
        tick_gappy = 1'b1;
        send_check(8'h5A, 7'b001_1111);
        send_check(8'h0F, 7'b010_1100);
        tick_gappy = 1'b0;

        // R7 break while idle
        line_ctrl = 7'b100_0011;
        repeat (4) @(negedge clk);
        chk(stx == 1'b0, "R7", int'(stx), 0);
        line_ctrl = 7'b000_0011;
        @(negedge clk);
        chk(stx == 1'b1, "R7", int'(stx), 1);
        // R7 break during a frame keeps timing
        send_check(8'h55, 7'b100_0011);
        line_ctrl = 7'b000_0011;
        @(negedge clk);

        // R8 back-to-back frames and R10 ignored write
        line_ctrl = 7'b000_0011;
        write_byte(8'hC3);
        @(negedge clk);
        chk(stx == 1'b0, "R8", int'(stx), 0);
        fork
            rx_frame(8'hC3, 7'b000_0011, 1'b0);
            begin
                repeat (20) @(negedge clk);
                write_byte(8'h81);
                chk(hold_empty == 1'b0, "R8", int'(hold_empty), 0);
                repeat (3) @(negedge clk);
                write_byte(8'h7E);
                chk(hold_empty == 1'b0, "R10", int'(hold_empty), 0);
            end
        join
        @(negedge clk);
        chk(stx == 1'b0, "R8", int'(stx), 0);
        chk(hold_empty == 1'b1, "R8", int'(hold_empty), 1);
        rx_frame(8'h81, 7'b000_0011, 1'b1);
        stayed_high = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (stx != 1'b1 || tx_empty != 1'b1) stayed_high = 1'b0;
        end
        chk(stayed_high, "R10", int'(stayed_high), 1);

        // random frames
        for (int n = 0; n < 30; n++) begin
            tick_gappy = 1'($urandom % 2);
            send_check(8'($urandom), 7'($urandom) & 7'h3F);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule